// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Condition Flags

This block is a purely combinational arithmetic and logic unit. It accepts two operands and a four-bit operation code. In the same cycle it returns a result and four condition flags: zero, negative, carry and overflow. It also raises a signal that tells the surrounding datapath not to store the result. That signal is asserted for the compare operation, which is evaluated only for its flags.

Each operation follows a fixed carry and overflow rule:

- Shifts capture the bit that leaves the operand in the carry flag.
- Multiply reports in the carry flag whether the upper half of the product holds a non-zero value.
- Division by zero has a defined outcome.

The divider is a restoring array and the multiplier is a partial-product array. Both settle without a clock, so a host pipeline can register the outputs at any stage boundary. The operand width is a parameter with a default of 8. The encodings below assume that default.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add): the result is (A+B) mod 256. C is the carry out of bit 7. V is bit 7 of ((A xor R) and (B xor R)).
- R2: Code 1 (subtract): the result is A + not(B) + 1, mod 256. C is the raw adder carry, so C=1 exactly when A >= B unsigned. V is bit 7 of ((A xor B) and (A xor R)).
- R3: Codes 2, 3 and 4 return A AND B, A OR B and A XOR B respectively, with C=0 and V=0.
- R4: Code 5 returns A shifted left by one with a 0 filled into bit 0, and C=A[7]. Code 6 returns A shifted right by one with a 0 filled into bit 7, and C=A[0]. For both codes V=0, and operand B has no effect.
- R5: Code 7 returns the low 8 bits of A*B. C=1 exactly when A*B > 255, and V=0.
- R6: Code 8 with B != 0 returns floor(A/B) with C=0 and V=0. With B=0 it returns 0 with C=1 and V=1.
- R7: Code 9 (compare) gives the same result and the same flags as code 1, and asserts `no_wb`. For every other code `no_wb` is 0.
- R8: Codes 10 to 15 return A unchanged with C=0 and V=0.
- R9: For every code, Z=1 exactly when the result is 0, and N equals result bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | First operand (A) |
| op_b | input | 8 | Second operand (B) |
| op_code | input | 4 | Operation code, 0..15 |
| result | output | 8 | Operation result |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 7 |
| flag_c | output | 1 | Carry, no-borrow, shift-out, product-high or divide-by-zero indicator |
| flag_v | output | 1 | Signed overflow, or divide-by-zero indicator |
| no_wb | output | 1 | Result must not be written back (compare) |

## Verification
The block holds no state, so any defect in a carry chain, partial-product row or divider stage shows up at the ports as soon as the operands are applied. For that reason every operand pair for every code is swept, and each result is compared against an arithmetic model. A broken restoring stage corrupts only the quotients whose trial subtraction passes through that stage. A wrong carry link shows up only on operand pairs that propagate through it. Sweeping every pair is what exposes both kinds of error.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SHL = 4'd5,
        OP_SHR = 4'd6,
        OP_MUL = 4'd7,
        OP_DIV = 4'd8,
        OP_CMP = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic alu_flags_t make_flags(input logic is_zero, input logic msb,
                                              input logic cy, input logic ov);
        alu_flags_t f;
        f.z = is_zero;
        f.n = msb;
        f.c = cy;
        f.v = ov;
        return f;
    endfunction

    function automatic logic uses_subtract(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0]   cy;
    logic [W-1:0] bm;

    assign cy[0] = sub;
    assign bm    = b ^ {W{sub}};

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ bm[i] ^ cy[i];
        assign cy[i+1] = (a[i] & bm[i]) | (a[i] & cy[i]) | (bm[i] & cy[i]);
    end

    assign cout = cy[W];

    always_comb begin
        if (sub) ovf = (a[W-1] ^ b[W-1]) & (a[W-1] ^ sum[W-1]);
        else     ovf = (a[W-1] ^ sum[W-1]) & (b[W-1] ^ sum[W-1]);
    end
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic         hi_nz
);
    localparam int PW = 2 * W;

    logic [PW-1:0] acc [0:W];

    assign acc[0] = '0;

    for (genvar k = 0; k < W; k++) begin : g_row
        logic [PW-1:0] pp;
        assign pp       = b[k] ? ({{W{1'b0}}, a} << k) : '0;
        assign acc[k+1] = acc[k] + pp;
    end

    assign lo    = acc[W][W-1:0];
    assign hi_nz = |acc[W][PW-1:W];
endmodule

// File: rtl/alu8_div.sv
module alu8_div #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quot,
    output logic         by_zero
);
    logic [W-1:0] rem [0:W];
    logic [W-1:0] q;

    assign rem[0] = '0;

    for (genvar k = 0; k < W; k++) begin : g_stage
        logic [W:0]   part;
        logic [W+1:0] diff;
        logic         borrow;
        assign part      = {rem[k], a[W-1-k]};
        assign diff      = {1'b0, part} - {2'b00, b};
        assign borrow    = diff[W+1];
        assign q[W-1-k]  = ~borrow;
        assign rem[k+1]  = borrow ? part[W-1:0] : diff[W-1:0];
    end

    assign by_zero = (b == '0);
    assign quot    = by_zero ? '0 : q;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic [OPC_W-1:0] op_code,
    output logic [W-1:0]     result,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_c,
    output logic             flag_v,
    output logic             no_wb
);
    alu_op_e    op;
    logic [W-1:0] as_sum, mul_lo, div_q;
    logic       as_cout, as_ovf, mul_hi, div_zero;
    logic [W-1:0] res;
    logic       cy, ov;
    alu_flags_t flg;

    assign op = alu_op_e'(op_code);

    alu8_addsub #(.W(W)) u_addsub (
        .a(op_a), .b(op_b), .sub(uses_subtract(op)),
        .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
    );

    alu8_mul #(.W(W)) u_mul (
        .a(op_a), .b(op_b), .lo(mul_lo), .hi_nz(mul_hi)
    );

    alu8_div #(.W(W)) u_div (
        .a(op_a), .b(op_b), .quot(div_q), .by_zero(div_zero)
    );

    always_comb begin
        res = op_a;
        cy  = 1'b0;
        ov  = 1'b0;
        case (op)
            OP_ADD, OP_SUB, OP_CMP: begin
                res = as_sum;
                cy  = as_cout;
                ov  = as_ovf;
            end
            OP_AND: res = op_a & op_b;
            OP_OR:  res = op_a | op_b;
            OP_XOR: res = op_a ^ op_b;
            OP_SHL: begin
                res = {op_a[W-2:0], 1'b0};
                cy  = op_a[W-1];
            end
            OP_SHR: begin
                res = {1'b0, op_a[W-1:1]};
                cy  = op_a[0];
            end
            OP_MUL: begin
                res = mul_lo;
                cy  = mul_hi;
            end
            OP_DIV: begin
                res = div_q;
                cy  = div_zero;
                ov  = div_zero;
            end
            default: ;
        endcase
    end

    assign flg    = make_flags(res == '0, res[W-1], cy, ov);
    assign result = res;
    assign flag_z = flg.z;
    assign flag_n = flg.n;
    assign flag_c = flg.c;
    assign flag_v = flg.v;
    assign no_wb  = (op == OP_CMP);
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [3:0]   op_code,
    input logic [W-1:0] result,
    input logic         flag_z,
    input logic         flag_n,
    input logic         flag_c,
    input logic         flag_v,
    input logic         no_wb
);
    always_comb begin
        // R9
        zero_flag_chk: assert (flag_z == (result == '0));
        // R9
        neg_flag_chk: assert (flag_n == result[W-1]);
        // R7
        no_wb_chk: assert (no_wb == (op_code == 4'd9));
        // R3
        if (op_code >= 4'd2 && op_code <= 4'd4) begin
            logic_cv_chk: assert (!flag_c && !flag_v);
        end
        // R4
        if (op_code == 4'd5) begin
            shl_out_chk: assert (flag_c == op_a[W-1] && !result[0] && !flag_v);
        end
        // R4
        if (op_code == 4'd6) begin
            shr_out_chk: assert (flag_c == op_a[0] && !result[W-1] && !flag_v);
        end
        // R5
        if (op_code == 4'd7) begin
            mul_v_chk: assert (!flag_v);
        end
        // R6
        if (op_code == 4'd8 && op_b == '0) begin
            div_zero_chk: assert (result == '0 && flag_c && flag_v);
        end
        // R2
        if (op_code == 4'd1 || op_code == 4'd9) begin
            no_borrow_chk: assert (flag_c == (op_a >= op_b));
        end
        // R8
        if (op_code >= 4'd10) begin
            pass_through_chk: assert (result == op_a && !flag_c && !flag_v);
        end
    end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .op_a(op_a), .op_b(op_b), .op_code(op_code), .result(result),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
    .no_wb(no_wb)
);

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] op_a = '0, op_b = '0;
    logic [3:0] op_code = '0;
    logic [7:0] result;
    logic       flag_z, flag_n, flag_c, flag_v, no_wb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    alu8_core #(.W(8)) uut (
        .op_a(op_a), .op_b(op_b), .op_code(op_code), .result(result),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
        .no_wb(no_wb)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 190000", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic string tag_of(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R3";
            5, 6: return "R4";
            7: return "R5";
            8: return "R6";
            9: return "R7";
            default: return "R8";
        endcase
    endfunction

    // packed expectation: {result[7:0], z, n, c, v, no_wb}
    function automatic logic [12:0] model(input int a, input int b, input int op);
        int r = a, c = 0, v = 0, w = 0, s;
        case (op)
            0: begin s = a + b; r = s & 255; c = s >> 8;
                     v = (((a ^ r) & (b ^ r) & 128) != 0) ? 1 : 0; end
            1, 9: begin s = a + ((~b) & 255) + 1; r = s & 255; c = (s >> 8) & 1;
                     v = (((a ^ b) & (a ^ r) & 128) != 0) ? 1 : 0;
                     w = (op == 9) ? 1 : 0; end
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: begin r = (a << 1) & 255; c = (a >> 7) & 1; end
            6: begin r = a >> 1; c = a & 1; end
            7: begin s = a * b; r = s & 255; c = (s > 255) ? 1 : 0; end
            8: if (b == 0) begin r = 0; c = 1; v = 1; end
               else r = a / b;
            default: ;
        endcase
        return {r[7:0], (r == 0), r[7], c[0], v[0], w[0]};
    endfunction

    function automatic logic [12:0] observed();
        return {result, flag_z, flag_n, flag_c, flag_v, no_wb};
    endfunction

    task automatic check(input string req, input logic [12:0] exp, input string what);
        logic [12:0] got = observed();
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: a=%0d b=%0d op=%0d got res=%0d znvc_w=%b expected res=%0d znvc_w=%b",
                     req, what, op_a, op_b, op_code, got[12:5], got[4:0], exp[12:5], exp[4:0]);
        end
    endtask

    task automatic apply(input int a, input int b, input int op);
        op_a = a[7:0]; op_b = b[7:0]; op_code = op[3:0];
        #0.001;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 idle state after reset: add of zeros gives zero result, Z=1
        apply(0, 0, 0);
        check("R9", 13'b00000000_1_0_0_0_0, "idle zero");

        // directed corners
        apply(8'h7F, 8'h01, 0); check("R1", model(127, 1, 0), "signed overflow add");
        apply(8'hFF, 8'h01, 0); check("R1", model(255, 1, 0), "carry out add");
        apply(8'h80, 8'h01, 1); check("R2", model(128, 1, 1), "signed overflow sub");
        apply(8'h03, 8'h05, 1); check("R2", model(3, 5, 1), "borrow sub");
        apply(8'h81, 8'h00, 5); check("R4", model(129, 0, 5), "shl carry");
        apply(8'h81, 8'hFF, 6); check("R4", model(129, 255, 6), "shr carry, B ignored");
        apply(8'h10, 8'h10, 7); check("R5", model(16, 16, 7), "product high nonzero");
        apply(8'h0F, 8'h11, 7); check("R5", model(15, 17, 7), "product 255 no carry");
        apply(8'hC8, 8'h00, 8); check("R6", 13'b00000000_1_0_1_1_0, "divide by zero");
        apply(8'h05, 8'h05, 9); check("R7", model(5, 5, 9), "compare equal no writeback");
        apply(8'hA5, 8'h3C, 12); check("R8", model(165, 60, 12), "pass through");
        apply(8'hF0, 8'h0F, 2); check("R3", model(240, 15, 2), "and zero result");

        // exhaustive sweep of every code and operand pair
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    apply(a, b, op);
                    check({tag_of(op), "/R9"}, model(a, b, op), "sweep");
                end
            end
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule